// File: doc/BRIEF.md
# Differential Sliced-Weight Shift-Add Combiner

The combiner rebuilds one signed partial result per output channel for a single input-bit iteration of an analog array multiply. Every weight is held as eight 2-bit slices on eight columns, and positive and negative weights sit in two separate arrays. One time-shared converter delivers 8-bit column codes one after another. The block scales each code by four to the power of its slice position. It sums the positive-array codes and subtracts the negative-array codes. Each finished channel result is put on a valid/ready output stream tagged with its channel number, and sixteen channels are served in rotation.

Samples enter on a valid/ready stream. A sample transfers on a cycle where in_valid and in_ready are both high. A result transfers on a cycle where out_valid and out_ready are both high, and it is held unchanged until that happens. Back-pressure is applied only when it must be. While a result is waiting, the block keeps accepting the first fifteen samples of the next channel. It lowers in_ready only for that channel's final sample, and only while the output register is still occupied and out_ready is low.

A sample that arrives out of its required place sets a sticky error flag. The block then drops the channel being assembled and restarts assembly with the next channel number.

Top module: `shift_add_combiner`

## Requirements
- R1: After reset, out_valid is 0, seq_error is 0 and in_ready is 1, and the first channel to be assembled is channel 0.
- R2: Each channel takes exactly sixteen samples in a fixed order. The first eight come from the positive array (in_neg = 0) with slice indices 0,1,...,7. The next eight come from the negative array (in_neg = 1) with slice indices 0,1,...,7.
- R3: The result equals the sum of the positive-array codes times 4^slice, minus the sum of the negative-array codes times 4^slice, as a 24-bit two's-complement value. The full range of ±5,570,475 is exact.
- R4: out_valid rises in the cycle after the sixteenth sample of a channel transfers. out_chan carries that channel's number. Channel numbers count 0 to 15 and then wrap to 0.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_result and out_chan stay unchanged.
- R6: in_ready is 0 only when the next expected sample is a channel's sixteenth, out_valid is 1 and out_ready is 0. A new result may be loaded in the same cycle that the previous one transfers.
- R7: A transferred sample whose slice index or in_neg differs from the expected one sets seq_error in the next cycle. The sample is discarded. The channel being assembled never produces a result. Assembly restarts at positive slice 0 with the next channel number.
- R8: Once set, seq_error stays 1 until reset.
- R9: A cycle in which no sample transfers leaves the assembly state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Combiner can take the sample |
| in_code | input | 8 | Converter code of one column |
| in_slice | input | 3 | Slice position of the column, 0..7 |
| in_neg | input | 1 | 0 = positive array, 1 = negative array |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 24 | Signed partial result |
| out_chan | output | 4 | Channel number of the result |
| seq_error | output | 1 | Sticky out-of-order flag |

## Verification
Two pairs of events can fall in the same cycle. In the first, a channel's final sample is loaded in the same cycle that the previous result transfers. In the second, an out-of-order final sample is accepted at the moment a stall lifts. The bench provokes both by holding out_ready low across whole channels and then releasing it exactly while a final sample is pending, some of those samples carrying a wrong slice or array flag. A behavioural reference model predicts in_ready, out_valid, out_result, out_chan and seq_error for every cycle and is compared on each falling edge. The judgement is whether the stalled result survives intact, whether the next one follows with the right channel number, and whether a discarded channel leaves a gap in the numbering.

// File: rtl/shift_add_pkg.sv
package shift_add_pkg;
  typedef enum logic {
    ARR_POS = 1'b0,
    ARR_NEG = 1'b1
  } array_sel_e;

  function automatic int unsigned geo_sum(input int unsigned base_bits, input int unsigned terms);
    int unsigned s;
    s = 0;
    for (int k = 0; k < int'(terms); k++) s += (1 << (base_bits * k));
    return s;
  endfunction
endpackage

// File: rtl/sac_order_tracker.sv
module sac_order_tracker #(
  parameter int SLICES   = 8,
  parameter int CHANNELS = 16,
  localparam int SL_W    = $clog2(SLICES),
  localparam int POS_W   = $clog2(2 * SLICES),
  localparam int CHAN_W  = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [SL_W-1:0]   slice,
  input  logic              neg,
  output logic              exp_last,
  output logic              seq_ok,
  output logic [CHAN_W-1:0] chan,
  output logic              err
);
  import shift_add_pkg::*;

  logic [POS_W-1:0] pos_q;
  logic [SL_W-1:0]  exp_slice;
  array_sel_e       exp_arr;
  logic             close_chan;

  assign exp_slice  = pos_q[SL_W-1:0];
  assign exp_arr    = pos_q[POS_W-1] ? ARR_NEG : ARR_POS;
  assign exp_last   = (pos_q == POS_W'(2 * SLICES - 1));
  assign seq_ok     = (slice == exp_slice) && (neg == logic'(exp_arr));
  assign close_chan = accept && (!seq_ok || exp_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      chan  <= '0;
      err   <= 1'b0;
    end else if (accept) begin
      if (close_chan) begin
        pos_q <= '0;
        chan  <= (chan == CHAN_W'(CHANNELS - 1)) ? '0 : chan + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
      if (!seq_ok) err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8

  AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    close_chan |=> (chan == (($past(chan) == CHAN_W'(CHANNELS - 1)) ? '0 : $past(chan) + 1'b1))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(chan) && $stable(exp_last))); // R9
endmodule

// File: rtl/sac_slice_weigher.sv
module sac_slice_weigher #(
  parameter int CODE_W     = 8,
  parameter int SLICES     = 8,
  parameter int SLICE_BITS = 2,
  parameter int RES_W      = 24,
  localparam int SL_W      = $clog2(SLICES)
) (
  input  logic [CODE_W-1:0]       code,
  input  logic [SL_W-1:0]         slice,
  input  logic                    neg,
  output logic signed [RES_W-1:0] term
);
  logic [RES_W-1:0] scaled [SLICES];

  for (genvar k = 0; k < SLICES; k++) begin : g_shift
    assign scaled[k] = RES_W'(code) << (SLICE_BITS * k);
  end

  logic [RES_W-1:0] picked;
  always_comb begin
    picked = '0;
    for (int k = 0; k < SLICES; k++) begin
      if (slice == SL_W'(k)) picked = scaled[k];
    end
  end

  assign term = neg ? -$signed(picked) : $signed(picked);
endmodule

// File: rtl/sac_accum.sv
module sac_accum #(
  parameter int RES_W  = 24,
  parameter int CHAN_W = 4,
  parameter int MAX_MAG = 5570475
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    seq_ok,
  input  logic                    last,
  input  logic signed [RES_W-1:0] term,
  input  logic [CHAN_W-1:0]       chan,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [RES_W-1:0] out_result,
  output logic [CHAN_W-1:0]       out_chan
);
  logic signed [RES_W-1:0] acc_q;
  logic                    load;

  assign load = accept && seq_ok && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_chan   <= '0;
    end else begin
      if (accept) begin
        if (!seq_ok || last) acc_q <= '0;
        else                 acc_q <= acc_q + term;
      end
      if (load) begin
        out_result <= acc_q + term;
        out_chan   <= chan;
        out_valid  <= 1'b1;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_chan))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) <= MAX_MAG) && (int'(acc_q) >= -MAX_MAG)); // R3

  AST_EMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept && seq_ok && last)); // R7
endmodule

// File: rtl/shift_add_combiner.sv
module shift_add_combiner #(
  parameter int CODE_W     = 8,
  parameter int SLICES     = 8,
  parameter int SLICE_BITS = 2,
  parameter int CHANNELS   = 16,
  parameter int RES_W      = 24,
  localparam int SL_W      = $clog2(SLICES),
  localparam int CHAN_W    = $clog2(CHANNELS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [CODE_W-1:0]       in_code,
  input  logic [SL_W-1:0]         in_slice,
  input  logic                    in_neg,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [RES_W-1:0] out_result,
  output logic [CHAN_W-1:0]       out_chan,
  output logic                    seq_error
);
  import shift_add_pkg::*;

  localparam int MAX_MAG = int'((2 ** CODE_W) - 1) * int'(geo_sum(SLICE_BITS, SLICES));

  logic                    accept, exp_last, seq_ok;
  logic [CHAN_W-1:0]       chan;
  logic signed [RES_W-1:0] term;

  assign in_ready = !(exp_last && out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  sac_order_tracker #(.SLICES(SLICES), .CHANNELS(CHANNELS)) i_track (
    .clk(clk), .rst_n(rst_n), .accept(accept), .slice(in_slice), .neg(in_neg),
    .exp_last(exp_last), .seq_ok(seq_ok), .chan(chan), .err(seq_error)
  );

  sac_slice_weigher #(.CODE_W(CODE_W), .SLICES(SLICES), .SLICE_BITS(SLICE_BITS), .RES_W(RES_W)) i_weigh (
    .code(in_code), .slice(in_slice), .neg(in_neg), .term(term)
  );

  sac_accum #(.RES_W(RES_W), .CHAN_W(CHAN_W), .MAX_MAG(MAX_MAG)) i_acc (
    .clk(clk), .rst_n(rst_n), .accept(accept), .seq_ok(seq_ok), .last(exp_last),
    .term(term), .chan(chan), .out_ready(out_ready),
    .out_valid(out_valid), .out_result(out_result), .out_chan(out_chan)
  );

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready)); // R6
endmodule

// File: tb/test_shift_add_combiner.sv
module test_shift_add_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_code = '0;
  logic [2:0] in_slice = '0;
  logic in_neg = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, seq_error;
  logic signed [23:0] out_result;
  logic [3:0] out_chan;

  always #2 clk = ~clk;

  shift_add_combiner i_shift_add_combiner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_slice(in_slice), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_chan(out_chan), .seq_error(seq_error)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int rdy_mode = 0;
  bit done = 0;

  // reference model state
  int m_pos = 0, m_chan = 0, m_acc = 0, m_res = 0, m_ochan = 0;
  bit m_ov = 0, m_err = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rdy, fire, accd;
      int got;
      cycles++;
      exp_rdy = !((m_pos == 15) && m_ov && !out_ready);
      check("R6 in_ready", int'(in_ready), int'(exp_rdy));
      check("R4 out_valid", int'(out_valid), int'(m_ov));
      check("R8 seq_error", int'(seq_error), int'(m_err));
      if (m_ov) begin
        got = $signed(out_result);
        check("R3 out_result", got, m_res);
        check("R4 out_chan", int'(out_chan), m_ochan);
      end
      // transition at the coming edge (R9: nothing moves without a transfer)
      fire = m_ov && out_ready;
      accd = in_valid && exp_rdy;
      if (fire) m_ov = 0;
      if (accd) begin
        if (int'(in_slice) != (m_pos % 8) || int'(in_neg) != (m_pos / 8)) begin
          m_err = 1; m_acc = 0; m_pos = 0; m_chan = (m_chan + 1) % 16;  // R7
        end else begin
          int t;
          t = int'(in_code) << (2 * int'(in_slice));
          m_acc = in_neg ? m_acc - t : m_acc + t;
          if (m_pos == 15) begin
            m_res = m_acc; m_ochan = m_chan; m_ov = 1;
            m_acc = 0; m_pos = 0; m_chan = (m_chan + 1) % 16;
          end else m_pos++;
        end
      end
      if (cycles > 100000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  // consumer side
  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = 1'($urandom_range(0, 1));
        default: out_ready = 1'b0;
      endcase
    end
  end

  task automatic send(input int code, input int sl, input bit ng);
    in_valid = 1'b1; in_code = 8'(code); in_slice = 3'(sl); in_neg = ng;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_chan(input int pc[8], input int nc[8], input bit gaps);
    for (int k = 0; k < 8; k++) begin
      send(pc[k], k, 1'b0);
      if (gaps && k[0]) begin @(posedge clk); #1; end
    end
    for (int k = 0; k < 8; k++) send(nc[k], k, 1'b1);
  endtask

  task automatic drain();
    rdy_mode = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    int pc[8], nc[8];
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 seq_error", int'(seq_error), 0);
    check("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 max positive, channel 0 (R1 first channel)
    foreach (pc[k]) begin pc[k] = 255; nc[k] = 0; end
    send_chan(pc, nc, 0);
    // R3 max negative
    foreach (pc[k]) begin pc[k] = 0; nc[k] = 255; end
    send_chan(pc, nc, 1);
    // R2 single slices, cancelling and mixed
    foreach (pc[k]) begin pc[k] = k * 30 + 1; nc[k] = 200 - k * 20; end
    send_chan(pc, nc, 0);
    foreach (pc[k]) begin pc[k] = 77; nc[k] = 77; end
    send_chan(pc, nc, 1);
    drain();

    // R5/R6 stall: result held while next channel fills and waits
    rdy_mode = 2;
    foreach (pc[k]) begin pc[k] = 3 + k; nc[k] = 1; end
    send_chan(pc, nc, 0);
    fork
      begin
        foreach (pc[k]) begin pc[k] = 9; nc[k] = 250 - k; end
        send_chan(pc, nc, 0);
      end
      begin repeat (40) @(posedge clk); #1; rdy_mode = 0; end
    join
    drain();

    // random back-pressure over many channels (R4 wrap)
    rdy_mode = 1;
    for (int c = 0; c < 20; c++) begin
      foreach (pc[k]) begin pc[k] = $urandom_range(0, 255); nc[k] = $urandom_range(0, 255); end
      send_chan(pc, nc, c[0]);
    end
    drain();

    // R7 skipped slice index
    for (int k = 0; k < 4; k++) send(10, k, 1'b0);
    send(10, 5, 1'b0);
    foreach (pc[k]) begin pc[k] = 1; nc[k] = 2; end
    send_chan(pc, nc, 0);
    // R7 wrong array flag at position 8
    for (int k = 0; k < 8; k++) send(50, k, 1'b0);
    send(50, 0, 1'b0);
    send_chan(pc, nc, 0);
    drain();

    // R7 with R6: bad final sample accepted when the stall lifts
    rdy_mode = 2;
    send_chan(pc, nc, 0);
    for (int k = 0; k < 8; k++) send(4, k, 1'b0);
    for (int k = 0; k < 7; k++) send(4, k, 1'b1);
    fork
      send(4, 7, 1'b0);
      begin repeat (10) @(posedge clk); #1; rdy_mode = 0; end
    join
    foreach (pc[k]) begin pc[k] = 255; nc[k] = 128; end
    send_chan(pc, nc, 1);
    drain();

    repeat (5) @(posedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule